// File: doc/BRIEF.md
# Programmable Reset Supervisor Timer

This block drives the active-low system reset of a chip. The reset is pulled low at once when a supply-good indication drops, or when software raises a one-shot reset request. Once every cause has gone, the reset stays low for a hold-off time. A 2-bit code selects that time as 1, 2, 4 or 8 times a base count of ticks. With the default base of 125 and a millisecond tick, the four choices are 125, 250, 500 and 1000 ms.

The timer counts pulses on a tick input, so it does not depend on the frequency of the block clock. The output is meant for an open-drain pad, so the block provides both the reset level and a pull-down enable. Three registered status bits go to the register bank: supply below trip point, reset active, and not yet past the power-on level. The software request bit is visible too. It clears itself during the reset period.

Top module: `rstsup_top`

## Requirements
- R1: Delay code 2'b00, 2'b01, 2'b10 and 2'b11 select a hold-off of BASE_TICKS, 2*BASE_TICKS, 4*BASE_TICKS and 8*BASE_TICKS ticks respectively.
- R2: While `supply_ok_i` is 0, `rst_out_n_o` is 0 in that same cycle, whatever the state of the hold-off counter.
- R3: A tick counts toward the hold-off only in a cycle in which no cause (supply low or request bit set) is present. Counting starts with the first cycle free of any cause. `rst_out_n_o` goes to 1 right after the clock edge that samples the last required tick.
- R4: If the supply drops during a hold-off, the count restarts from the full selected length once the supply returns.
- R5: The delay code is taken in the last cycle in which a cause is present. Changing `dly_code_i` during the hold-off does not change its length.
- R6: While `rst_ni` is low and after it is released, the reset output is active. The first hold-off uses code 2'b11 (8*BASE_TICKS ticks), whatever `dly_code_i` is.
- R7: A one-cycle pulse on `sw_rst_i` sets `sw_bit_o` to 1 after the next edge, and the reset output is active while it is set. The bit returns to 0 after one more edge while the reset stays active. The hold-off for the selected code follows.
- R8: `trip_o` equals the inverse of `supply_ok_i` one cycle later (1 means below the trip point). It reads 0 during block reset.
- R9: `rst_status_o` is 1 one cycle after a cycle in which the reset output is active, and 0 one cycle after a cycle in which it is inactive. It reads 1 during block reset.
- R10: `not_ready_o` equals the inverse of `por_ok_i` one cycle later. It reads 1 during block reset.
- R11: `rst_pd_o` (pull-down enable of the open-drain pad) is 1 exactly when `rst_out_n_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| tick_i | input | 1 | One-cycle timebase pulse (nominally 1 ms) |
| supply_ok_i | input | 1 | 1 while supply is above the trip point |
| por_ok_i | input | 1 | 1 while supply is above the power-on level |
| dly_code_i | input | 2 | Hold-off length code |
| sw_rst_i | input | 1 | Pulse that sets the software reset request bit |
| rst_out_n_o | output | 1 | Reset level, active low |
| rst_pd_o | output | 1 | Pull-down enable for the open-drain reset pad |
| sw_bit_o | output | 1 | Software reset request bit (self-clearing) |
| trip_o | output | 1 | Status: supply below trip point |
| rst_status_o | output | 1 | Status: reset output active |
| not_ready_o | output | 1 | Status: supply not yet past power-on level |

## Verification
Most internal faults show up as a change in the length of the reset pulse. A wrong load value, a counter that skips or counts ticks during a cause, or a restart that fails to reload all move the release edge by a whole number of ticks. That edge is the moment the bench compares with its count of ticks delivered. A hold flag stuck low shows as a reset that releases in the same cycle the supply returns. A request bit that does not clear keeps the reset low past the expected tick. The status flops are exposed one cycle after any change at the inputs, so a wrong one is seen on the next edge.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

    // Code loaded by the block reset: longest hold-off.
    localparam logic [1:0] DLY_CODE_INIT = 2'b11;

    typedef struct packed {
        logic not_ready;
        logic trip;
        logic active;
    } rstsup_stat_t;

endpackage

// File: rtl/rstsup_swreq.sv
module rstsup_swreq (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    output logic req_o
);
    typedef struct packed {
        logic req;
    } swreq_state_t;

    swreq_state_t st_d, st_q;

    // The bit is held by a pulse and drops on the following edge; the
    // hold-off block takes over keeping the reset active from then on.
    always_comb begin
        st_d     = st_q;
        st_d.req = set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o = st_q.req;
endmodule

// File: rtl/rstsup_holdoff.sv
module rstsup_holdoff #(
    parameter int unsigned BASE_TICKS = 125,
    parameter logic [1:0]  INIT_CODE  = 2'b11
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       cause_i,
    input  logic       tick_i,
    input  logic [1:0] code_i,
    output logic       hold_o
);
    localparam int unsigned MAX_TICKS = BASE_TICKS * 8;
    localparam int unsigned CW        = $clog2(MAX_TICKS + 1);

    typedef struct packed {
        logic          hold;
        logic [CW-1:0] left;
    } hold_state_t;

    function automatic logic [CW-1:0] ticks_for(input logic [1:0] code);
        return CW'(BASE_TICKS) << code;
    endfunction

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cause_i) begin
            // Reload every cycle a cause is present: restart and code capture.
            st_d.hold = 1'b1;
            st_d.left = ticks_for(code_i);
        end else if (st_q.hold && tick_i) begin
            if (st_q.left <= CW'(1)) begin
                st_d.hold = 1'b0;
                st_d.left = '0;
            end else begin
                st_d.left = st_q.left - CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.hold <= 1'b1;
            st_q.left <= ticks_for(INIT_CODE);
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = st_q.hold;
endmodule

// File: rtl/rstsup_status.sv
module rstsup_status
    import rstsup_pkg::*;
(
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         supply_ok_i,
    input  logic         por_ok_i,
    input  logic         active_i,
    output rstsup_stat_t stat_o
);
    rstsup_stat_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.not_ready = ~por_ok_i;
        st_d.trip      = ~supply_ok_i;
        st_d.active    = active_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.not_ready <= 1'b1;
            st_q.trip      <= 1'b0;
            st_q.active    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q;
endmodule

// File: rtl/rstsup_top.sv
module rstsup_top
    import rstsup_pkg::*;
#(
    parameter int unsigned BASE_TICKS = 125
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       supply_ok_i,
    input  logic       por_ok_i,
    input  logic [1:0] dly_code_i,
    input  logic       sw_rst_i,
    output logic       rst_out_n_o,
    output logic       rst_pd_o,
    output logic       sw_bit_o,
    output logic       trip_o,
    output logic       rst_status_o,
    output logic       not_ready_o
);
    logic         sw_req;
    logic         cause;
    logic         hold;
    logic         active;
    rstsup_stat_t stat;

    rstsup_swreq u_swreq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (sw_rst_i),
        .req_o  (sw_req)
    );

    // Supply loss bypasses all state so the pad drops in the same cycle.
    assign cause = ~supply_ok_i | sw_req;

    rstsup_holdoff #(
        .BASE_TICKS (BASE_TICKS),
        .INIT_CODE  (DLY_CODE_INIT)
    ) u_holdoff (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cause_i (cause),
        .tick_i  (tick_i),
        .code_i  (dly_code_i),
        .hold_o  (hold)
    );

    assign active = cause | hold;

    rstsup_status u_status (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .supply_ok_i (supply_ok_i),
        .por_ok_i    (por_ok_i),
        .active_i    (active),
        .stat_o      (stat)
    );

    assign rst_out_n_o  = ~active;
    assign rst_pd_o     = active;
    assign sw_bit_o     = sw_req;
    assign trip_o       = stat.trip;
    assign rst_status_o = stat.active;
    assign not_ready_o  = stat.not_ready;
endmodule

// File: rtl/rstsup_chk.sv
module rstsup_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       tick_i,
    input logic       supply_ok_i,
    input logic       por_ok_i,
    input logic       sw_rst_i,
    input logic       rst_out_n_o,
    input logic       rst_pd_o,
    input logic       sw_bit_o,
    input logic       trip_o,
    input logic       rst_status_o,
    input logic       not_ready_o
);
    assert_supply_loss_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !supply_ok_i |-> !rst_out_n_o);

    assert_release_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_out_n_o) |-> $past(tick_i));

    assert_sw_active_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sw_bit_o |-> !rst_out_n_o);

    assert_sw_selfclear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sw_bit_o && !sw_rst_i) |=> !sw_bit_o);

    assert_trip_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (trip_o == !$past(supply_ok_i)));

    assert_status_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (rst_status_o == !$past(rst_out_n_o)));

    assert_ready_follow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (not_ready_o == !$past(por_ok_i)));

    assert_open_drain_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_pd_o != rst_out_n_o);
endmodule

bind rstsup_top rstsup_chk chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .supply_ok_i  (supply_ok_i),
    .por_ok_i     (por_ok_i),
    .sw_rst_i     (sw_rst_i),
    .rst_out_n_o  (rst_out_n_o),
    .rst_pd_o     (rst_pd_o),
    .sw_bit_o     (sw_bit_o),
    .trip_o       (trip_o),
    .rst_status_o (rst_status_o),
    .not_ready_o  (not_ready_o)
);

// File: tb/rstsup_top_tb_top.sv
`timescale 1ns/1ps
module rstsup_top_tb_top;
    localparam int unsigned BASE = 2;

    logic       clk_i = 1'b0;
    logic       rst_ni;
    logic       tick_i;
    logic       supply_ok_i;
    logic       por_ok_i;
    logic [1:0] dly_code_i;
    logic       sw_rst_i;
    logic       rst_out_n_o;
    logic       rst_pd_o;
    logic       sw_bit_o;
    logic       trip_o;
    logic       rst_status_o;
    logic       not_ready_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #5 clk_i = ~clk_i;

    rstsup_top #(.BASE_TICKS(BASE)) dut_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick_i),
        .supply_ok_i  (supply_ok_i),
        .por_ok_i     (por_ok_i),
        .dly_code_i   (dly_code_i),
        .sw_rst_i     (sw_rst_i),
        .rst_out_n_o  (rst_out_n_o),
        .rst_pd_o     (rst_pd_o),
        .sw_bit_o     (sw_bit_o),
        .trip_o       (trip_o),
        .rst_status_o (rst_status_o),
        .not_ready_o  (not_ready_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Inputs are applied 1 ns after an edge; outputs are read 1 ns after the next.
    task automatic step(input logic tk);
        tick_i = tk;
        @(posedge clk_i);
        #1;
    endtask

    function automatic logic tick_at(input int pat, input int i);
        case (pat)
            0:       return 1'b1;
            1:       return (i % 3) == 0;
            default: return ((i % 5) == 0) || ((i % 5) == 2);
        endcase
    endfunction

    // Expected: output high exactly once n ticks have been delivered in cause-free cycles.
    task automatic count_release(input int n, input int pat, input int restart_at,
                                 input bit change_code, input string req);
        int ticks     = 0;
        bit bad       = 1'b0;
        bit restarted = 1'b0;
        int got       = n;
        for (int i = 0; i < 400 && ticks < n + 2; i++) begin
            logic tk;
            tk = tick_at(pat, i);
            if (change_code && i == 1) dly_code_i = ~dly_code_i;
            if (!restarted && restart_at > 0 && ticks == restart_at) begin
                supply_ok_i = 1'b0;
                restarted   = 1'b1;
                #1;
                if (rst_out_n_o !== 1'b0) begin bad = 1'b1; got = -1; end
                step(tk);
                supply_ok_i = 1'b1;
                ticks = 0;
                if (rst_out_n_o !== 1'b0) begin bad = 1'b1; got = -2; end
            end else begin
                step(tk);
                if (tk) ticks++;
                if (rst_out_n_o !== (ticks >= n)) begin
                    if (!bad) got = ticks;
                    bad = 1'b1;
                end
            end
        end
        chk(!bad, req, got, n);
    endtask

    initial begin
        rst_ni      = 1'b0;
        tick_i      = 1'b0;
        supply_ok_i = 1'b1;
        por_ok_i    = 1'b1;
        dly_code_i  = 2'b00;
        sw_rst_i    = 1'b0;
        repeat (3) step(1'b0);
        chk(rst_out_n_o === 1'b0, "R6 reset active in block reset", rst_out_n_o, 0);
        chk(rst_pd_o === 1'b1, "R11 pull-down in block reset", rst_pd_o, 1);
        chk(rst_status_o === 1'b1, "R9 status in block reset", rst_status_o, 1);
        chk(trip_o === 1'b0, "R8 trip in block reset", trip_o, 0);
        chk(not_ready_o === 1'b1, "R10 not-ready in block reset", not_ready_o, 1);
        rst_ni = 1'b1;
        // R6: first hold-off uses code 11 although the input says 00.
        count_release(int'(BASE) * 8, 0, 0, 1'b0, "R6 initial hold-off");
        step(1'b0);
        chk(rst_status_o === 1'b0, "R9 status after release", rst_status_o, 0);
        chk(rst_pd_o === 1'b0, "R11 pull-down after release", rst_pd_o, 0);
        chk(not_ready_o === 1'b0, "R10 ready with power-on ok", not_ready_o, 0);

        for (int code = 0; code < 4; code++) begin
            for (int pat = 0; pat < 3; pat++) begin
                for (int use_sw = 0; use_sw < 2; use_sw++) begin
                    dly_code_i = 2'(code);
                    if (use_sw != 0) begin
                        sw_rst_i = 1'b1;
                        step(1'b0);
                        chk(sw_bit_o === 1'b1, "R7 request bit set", sw_bit_o, 1);
                        chk(rst_out_n_o === 1'b0, "R7 reset active by request", rst_out_n_o, 0);
                        sw_rst_i = 1'b0;
                        step(1'b1);
                        chk(sw_bit_o === 1'b0, "R7 request bit cleared", sw_bit_o, 0);
                        chk(rst_out_n_o === 1'b0, "R7 reset held after clear", rst_out_n_o, 0);
                        count_release(int'(BASE) << code, pat, 0, 1'b0, "R1 R3 R7 request hold-off");
                    end else begin
                        supply_ok_i = 1'b0;
                        #1;
                        chk(rst_out_n_o === 1'b0, "R2 same-cycle assertion", rst_out_n_o, 0);
                        step(1'b1);
                        chk(trip_o === 1'b1, "R8 trip set", trip_o, 1);
                        step(1'b1);
                        chk(rst_status_o === 1'b1, "R9 status set", rst_status_o, 1);
                        supply_ok_i = 1'b1;
                        count_release(int'(BASE) << code, pat, 0, 1'b0, "R1 R3 supply hold-off");
                        step(1'b0);
                        chk(trip_o === 1'b0, "R8 trip cleared", trip_o, 0);
                    end
                end
            end
        end

        // R4: supply drops after 3 of 4 ticks; full count again afterwards.
        dly_code_i  = 2'b01;
        supply_ok_i = 1'b0;
        step(1'b0);
        supply_ok_i = 1'b1;
        count_release(int'(BASE) * 2, 0, 3, 1'b0, "R4 restart on supply drop");

        // R5: code changed to 01 during a code-10 hold-off; length stays 4*BASE.
        dly_code_i  = 2'b10;
        supply_ok_i = 1'b0;
        step(1'b0);
        supply_ok_i = 1'b1;
        count_release(int'(BASE) * 4, 1, 0, 1'b1, "R5 code change ignored");

        // R10: power-on indication low and back.
        por_ok_i = 1'b0;
        step(1'b0);
        chk(not_ready_o === 1'b1, "R10 not-ready set", not_ready_o, 1);
        por_ok_i = 1'b1;
        step(1'b0);
        chk(not_ready_o === 1'b0, "R10 not-ready cleared", not_ready_o, 0);
        chk(rst_out_n_o === 1'b1, "R10 reset unaffected by power-on flag", rst_out_n_o, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end
endmodule